// File: doc/BRIEF.md
# Spanning-Tree Port State Gate

This block sits between a switch's address lookup and its forwarding and learning engines. It applies a rapid spanning-tree state to every port. Each port holds three control bits: transmit enable, receive enable and learning disable. Together these bits select one of three states. A discarding port neither passes user traffic nor learns addresses. A learning port learns addresses, but it only exchanges frames with the processor port. A forwarding port behaves normally.

Each frame arrives with its ingress port, the egress mask from the lookup, and a flag. The flag is set when the frame hit a static table entry marked to override the port state. The block returns a filtered egress mask and a learn-permit bit, both one clock later. Control frames that hit such an override entry still reach the processor port when the ingress port is blocked. When software switches learning off on a port, the block pulses a flush request that names the port, so that the port's address-table entries can be removed.

The control bits are loaded through a simple write interface: an enable, a port number and three bits. The processor port is the fifth port, at index 4.

Top module: `stp_port_gate`

## Requirements
- R1: Reset clears out_valid, out_dst_mask, out_learn_ok and flush_req. After reset, the processor port (index 4) holds tx=1, rx=1, learn_dis=0, and every other port holds tx=0, rx=0, learn_dis=1.
- R2: An egress bit e survives when it is requested and ingress rx=1 and port e has tx=1.
- R3: A requested egress port that fails every pass rule of R2, R4 and R5 is removed from the mask.
- R4: A learning port exchanges frames with the processor port only. Frames from the processor reach any requested port with learn_dis=0, and frames from an ingress port with learn_dis=0 reach the processor port.
- R5: With frm_override=1, a requested processor-port bit is kept whatever the ingress state. The override does not restore any other port.
- R6: out_learn_ok is 1 exactly when a valid frame's ingress port had learn_dis=0.
- R7: A write that moves a port's learn_dis from 0 to 1 produces flush_req high for one cycle, with flush_port equal to that port, in the cycle after the write. A write that leaves learn_dis at 1, or clears it, produces no flush.
- R8: Outputs are registered with a latency of one cycle. A frame is judged on the control state that was held before any write in the same cycle. When frm_valid=0 the next mask and learn_ok are 0.
- R9: A write whose cfg_port is NUM_PORTS or higher changes no state and produces no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_port | input | PORT_W | Port being written |
| cfg_tx_en | input | 1 | New transmit enable |
| cfg_rx_en | input | 1 | New receive enable |
| cfg_learn_dis | input | 1 | New learning disable |
| frm_valid | input | 1 | Frame lookup result present |
| frm_src | input | PORT_W | Ingress port of the frame |
| frm_dst_mask | input | NUM_PORTS | Egress mask from lookup |
| frm_override | input | 1 | Frame hit a static entry with override set |
| out_valid | output | 1 | Filtered result present |
| out_dst_mask | output | NUM_PORTS | Filtered egress mask |
| out_learn_ok | output | 1 | Source address may be learned |
| flush_req | output | 1 | One-cycle flush request |
| flush_port | output | PORT_W | Port to flush |

## Verification
The assertions assume that frm_valid and cfg_we are held low while reset is asserted. This means the first cycle after reset sees a clean history. They also assume that frm_src is always below NUM_PORTS when frm_valid is high. The stimulus drives every input at the falling edge, keeps all strobes low through reset, and uses only legal ingress ports. The only out-of-range port numbers it drives appear on the write interface, where they test R9.

// File: rtl/stp_gate_pkg.sv
package stp_gate_pkg;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic learn_dis;
  } port_ctl_t;

  localparam port_ctl_t CTL_DISCARD = '{tx_en: 1'b0, rx_en: 1'b0, learn_dis: 1'b1};
  localparam port_ctl_t CTL_FORWARD = '{tx_en: 1'b1, rx_en: 1'b1, learn_dis: 1'b0};

  // Decide whether one requested egress port may receive the frame.
  function automatic logic egress_allowed(port_ctl_t src_ctl, port_ctl_t dst_ctl,
                                          logic src_is_host, logic dst_is_host,
                                          logic override);
    logic normal_path, from_host, to_host;
    normal_path = src_ctl.rx_en & dst_ctl.tx_en;
    from_host   = src_is_host & ~dst_ctl.learn_dis;
    to_host     = dst_is_host & (~src_ctl.learn_dis | override);
    return normal_path | from_host | to_host;
  endfunction

  // A source address may be learned when learning is enabled on ingress.
  function automatic logic learn_allowed(port_ctl_t src_ctl);
    return ~src_ctl.learn_dis;
  endfunction

endpackage

// File: rtl/stp_cfg_bank.sv
module stp_cfg_bank
  import stp_gate_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 3,
  parameter int HOST_PORT = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [PORT_W-1:0]               cfg_port,
  input  logic                            cfg_tx_en,
  input  logic                            cfg_rx_en,
  input  logic                            cfg_learn_dis,
  output port_ctl_t [NUM_PORTS-1:0]       ctl_q,
  output logic                            flush_edge,
  output logic [PORT_W-1:0]               flush_edge_port
);

  logic [NUM_PORTS-1:0] sel;
  logic [NUM_PORTS-1:0] ld_rise;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam port_ctl_t RST_CTL = (p == HOST_PORT) ? CTL_FORWARD : CTL_DISCARD;

    assign sel[p]     = cfg_we && (cfg_port == PORT_W'(p));
    assign ld_rise[p] = sel[p] && cfg_learn_dis && !ctl_q[p].learn_dis;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[p] <= RST_CTL;
      end else if (sel[p]) begin
        ctl_q[p] <= '{tx_en: cfg_tx_en, rx_en: cfg_rx_en, learn_dis: cfg_learn_dis};
      end
    end
  end

  assign flush_edge      = |ld_rise;
  assign flush_edge_port = cfg_port;

endmodule

// File: rtl/stp_egress_filter.sv
module stp_egress_filter
  import stp_gate_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int PORT_W    = 3,
  parameter int HOST_PORT = 4
) (
  input  port_ctl_t [NUM_PORTS-1:0] ctl_q,
  input  logic                      frm_valid,
  input  logic [PORT_W-1:0]         frm_src,
  input  logic [NUM_PORTS-1:0]      frm_dst_mask,
  input  logic                      frm_override,
  output logic [NUM_PORTS-1:0]      keep_mask,
  output logic                      learn_permit
);

  port_ctl_t src_ctl;
  logic      src_is_host;

  always_comb begin
    src_ctl = CTL_DISCARD;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (frm_src == PORT_W'(p)) src_ctl = ctl_q[p];
    end
  end

  assign src_is_host = (frm_src == PORT_W'(HOST_PORT));

  for (genvar e = 0; e < NUM_PORTS; e++) begin : g_egress
    localparam logic IS_HOST = (e == HOST_PORT);
    assign keep_mask[e] = frm_valid && frm_dst_mask[e] &&
                          egress_allowed(src_ctl, ctl_q[e], src_is_host, IS_HOST, frm_override);
  end

  assign learn_permit = frm_valid && learn_allowed(src_ctl);

endmodule

// File: rtl/stp_port_gate.sv
module stp_port_gate
  import stp_gate_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int HOST_PORT = 4,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic                 cfg_tx_en,
  input  logic                 cfg_rx_en,
  input  logic                 cfg_learn_dis,
  input  logic                 frm_valid,
  input  logic [PORT_W-1:0]    frm_src,
  input  logic [NUM_PORTS-1:0] frm_dst_mask,
  input  logic                 frm_override,
  output logic                 out_valid,
  output logic [NUM_PORTS-1:0] out_dst_mask,
  output logic                 out_learn_ok,
  output logic                 flush_req,
  output logic [PORT_W-1:0]    flush_port
);

  port_ctl_t [NUM_PORTS-1:0] ctl_q;
  logic                      flush_edge;
  logic [PORT_W-1:0]         flush_edge_port;
  logic [NUM_PORTS-1:0]      keep_mask;
  logic                      learn_permit;

  stp_cfg_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .HOST_PORT(HOST_PORT)) cfg_i (
    .clk, .rst_n, .cfg_we, .cfg_port, .cfg_tx_en, .cfg_rx_en, .cfg_learn_dis,
    .ctl_q, .flush_edge, .flush_edge_port
  );

  stp_egress_filter #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .HOST_PORT(HOST_PORT)) filt_i (
    .ctl_q, .frm_valid, .frm_src, .frm_dst_mask, .frm_override, .keep_mask, .learn_permit
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_dst_mask <= '0;
      out_learn_ok <= 1'b0;
      flush_req    <= 1'b0;
      flush_port   <= '0;
    end else begin
      out_valid    <= frm_valid;
      out_dst_mask <= keep_mask;
      out_learn_ok <= learn_permit;
      flush_req    <= flush_edge;
      if (flush_edge) flush_port <= flush_edge_port;
    end
  end

endmodule

// File: rtl/stp_port_gate_chk.sv
module stp_port_gate_chk #(
  parameter int NUM_PORTS = 5,
  parameter int HOST_PORT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic                 cfg_learn_dis,
  input logic                 frm_valid,
  input logic [NUM_PORTS-1:0] frm_dst_mask,
  input logic                 frm_override,
  input logic                 out_valid,
  input logic [NUM_PORTS-1:0] out_dst_mask,
  input logic                 out_learn_ok,
  input logic                 flush_req
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(frm_valid)); // R8

  AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_dst_mask & ~$past(frm_dst_mask)) == '0)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_dst_mask == '0 && !out_learn_ok)); // R8

  AST_LEARN_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    out_learn_ok |-> out_valid); // R6

  AST_OVERRIDE_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(frm_override && frm_dst_mask[HOST_PORT])) |-> out_dst_mask[HOST_PORT]); // R5

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(cfg_we && cfg_learn_dis)); // R7

endmodule

bind stp_port_gate stp_port_gate_chk #(.NUM_PORTS(NUM_PORTS), .HOST_PORT(HOST_PORT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_learn_dis(cfg_learn_dis),
  .frm_valid(frm_valid), .frm_dst_mask(frm_dst_mask), .frm_override(frm_override),
  .out_valid(out_valid), .out_dst_mask(out_dst_mask), .out_learn_ok(out_learn_ok),
  .flush_req(flush_req)
);

// File: tb/stp_port_gate_tb_top.sv
`timescale 1ns/1ps
module stp_port_gate_tb_top;

  localparam int NP = 5;
  localparam int HOST = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [PW-1:0] cfg_port = '0;
  logic          cfg_tx_en = 1'b0, cfg_rx_en = 1'b0, cfg_learn_dis = 1'b0;
  logic          frm_valid = 1'b0;
  logic [PW-1:0] frm_src = '0;
  logic [NP-1:0] frm_dst_mask = '0;
  logic          frm_override = 1'b0;
  logic          out_valid, out_learn_ok, flush_req;
  logic [NP-1:0] out_dst_mask;
  logic [PW-1:0] flush_port;

  int checks = 0;
  int errors = 0;
  int tx[NP];
  int rx[NP];
  int ld[NP];

  always #2.5 clk = ~clk;

  stp_port_gate #(.NUM_PORTS(NP), .HOST_PORT(HOST)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_port, .cfg_tx_en, .cfg_rx_en, .cfg_learn_dis,
    .frm_valid, .frm_src, .frm_dst_mask, .frm_override,
    .out_valid, .out_dst_mask, .out_learn_ok, .flush_req, .flush_port
  );

  // One cycle: drive inputs, predict from the model, compare after the edge.
  task automatic step(input string tag, input bit we, input int wp, input bit wt,
                      input bit wr, input bit wl, input bit fv, input int fs,
                      input int fm, input bit fo);
    int  exp_mask;
    bit  exp_learn, exp_flush;
    cfg_we = we; cfg_port = PW'(wp); cfg_tx_en = wt; cfg_rx_en = wr; cfg_learn_dis = wl;
    frm_valid = fv; frm_src = PW'(fs); frm_dst_mask = NP'(fm); frm_override = fo;
    exp_mask = 0;
    for (int e = 0; e < NP; e++) begin
      bit ok;
      ok = 0;
      if (fv && fm[e]) begin
        if (rx[fs] == 1 && tx[e] == 1) ok = 1;
        if (fs == HOST && ld[e] == 0) ok = 1;
        if (e == HOST && (ld[fs] == 0 || fo)) ok = 1;
      end
      if (ok) exp_mask |= (1 << e);
    end
    exp_learn = fv && (ld[fs] == 0);
    exp_flush = we && wp < NP && wl && ld[wp] == 0;
    if (we && wp < NP) begin
      tx[wp] = wt; rx[wp] = wr; ld[wp] = wl;
    end
    @(posedge clk); #1;
    checks++;
    if (out_valid !== fv || out_dst_mask !== NP'(exp_mask) || out_learn_ok !== exp_learn ||
        flush_req !== exp_flush || (exp_flush && flush_port !== PW'(wp))) begin
      errors++;
      $display("FAIL %s: valid=%0b mask=%b learn=%0b flush=%0b port=%0d expected valid=%0b mask=%b learn=%0b flush=%0b port=%0d",
               tag, out_valid, out_dst_mask, out_learn_ok, flush_req, flush_port,
               fv, NP'(exp_mask), exp_learn, exp_flush, wp);
    end
    @(negedge clk);
  endtask

  task automatic wr_cfg(input string tag, input int p, input bit t, input bit r, input bit l);
    step(tag, 1, p, t, r, l, 0, 0, 0, 0);
  endtask

  task automatic frame(input string tag, input int s, input int m, input bit o);
    step(tag, 0, 0, 0, 0, 0, 1, s, m, o);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      tx[p] = (p == HOST); rx[p] = (p == HOST); ld[p] = (p != HOST);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (out_valid !== 0 || out_dst_mask !== '0 || out_learn_ok !== 0 || flush_req !== 0) begin
      errors++;
      $display("FAIL R1: outputs after reset valid=%0b mask=%b learn=%0b flush=%0b expected all zero",
               out_valid, out_dst_mask, out_learn_ok, flush_req);
    end
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    frame("R1", 0, 'h1F, 0);        // discarding ingress: nothing
    frame("R1", HOST, 'h1F, 0);     // host only reaches itself
    wr_cfg("R7", 0, 1, 1, 0);       // learn_dis 1->0: no flush
    wr_cfg("R7", 1, 1, 1, 0);
    frame("R2", 0, 'h1F, 0);        // 0,1,host
    frame("R3", 1, 'h06, 0);        // port 2 still blocked
    wr_cfg("R4", 2, 0, 0, 0);       // port 2 learning
    frame("R4", HOST, 'h07, 0);
    frame("R4", 2, 'h13, 0);
    frame("R6", 2, 'h01, 0);
    frame("R4", 0, 'h04, 0);        // forwarding to learning: dropped
    wr_cfg("R7", 3, 0, 0, 1);       // stays at 1: no flush
    frame("R5", 3, 'h13, 1);        // override keeps host only
    frame("R5", 3, 'h13, 0);
    wr_cfg("R7", 1, 0, 0, 1);       // 0->1: flush port 1
    wr_cfg("R7", 1, 0, 0, 1);       // repeat: no flush
    wr_cfg("R9", 5, 1, 1, 1);       // out of range
    wr_cfg("R9", 7, 0, 0, 1);
    frame("R9", 0, 'h1F, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 'h1F, 1); // invalid frame
    step("R8", 1, 0, 0, 0, 1, 1, 0, 'h11, 0); // frame sees old state; flush 0
    frame("R3", 0, 'h11, 0);
    frame("R2", HOST, 'h1F, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule